// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block lets a host read and write a sixteen-entry byte register file over a three-wire serial link. The link has a chip-enable line, a serial clock and one bidirectional data line. The host drives the data line for the address and for write data, and the block drives it for read data. The block runs on a fast system clock. It passes the three bus inputs through synchronizers and then finds the serial clock and chip-enable edges.

Each transaction starts when chip enable rises. The first byte is always an address byte. Its top bit selects the direction, and its low bits select the starting register. Any number of data bytes may follow. The register address steps up after each byte and wraps inside the sixteen-entry window. Bits travel least significant first in both directions. Every completed write byte also produces a one-cycle strobe with its address and data, so that external counters can be loaded. The lowest `TIME_N` registers hold a copy of a live time value, which is presented on a parallel input. That copy is taken only when chip enable rises, so the values read in one transaction stay fixed even while the live value moves.

Top module: `ser3w_slave`

## Requirements
- R1: Address and data bytes are shifted least significant bit first in both directions. Input bits are taken at serial-clock rising edges and output bits change after serial-clock falling edges.
- R2: The first byte after chip enable rises is the address. Its bit 7 set to 1 selects writes and set to 0 selects reads. Bits 3:0 select the register and bits 6:4 are ignored.
- R3: Each completed write data byte stores the byte into the addressed register. It also raises `wr_stb` with `wr_addr` and `wr_data` carrying that address and byte.
- R4: In a write burst the register address steps by one after each byte and wraps from 0xF to 0x0. On the bus this is 0x8F followed by 0x80.
- R5: In a read burst the register address steps by one after each byte and wraps from 0x0F to 0x00.
- R6: Registers 0 to `TIME_N`-1 are loaded from `live_time` (byte i at bits 8i+7:8i) only when chip enable rises. Changes to `live_time` during a transaction are not visible until the next transaction.
- R7: If chip enable falls before a write byte completes, the partial byte is dropped. No strobe is produced and no register changes.
- R8: `sio_oe` is high only in the read-data phase while chip enable is high. The first read bit is driven after the serial-clock falling edge that follows the last address bit. `sio_oe` is low during the address phase, during writes, and from four system clocks after chip enable falls.
- R9: After reset `sio_oe` and `wr_stb` are low and every register reads 0x00 until it is written or loaded.
- R10: `wr_stb` is high for exactly one system clock per completed write byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | Chip enable from the host, asynchronous |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| sio_in | input | 1 | Data line as seen at the pad |
| sio_out | output | 1 | Data value driven toward the pad during reads |
| sio_oe | output | 1 | Pad output enable for the data line |
| live_time | input | 8*TIME_N | Live time bytes, copied into registers 0 to TIME_N-1 at chip-enable rise |
| wr_stb | output | 1 | One-cycle strobe for each completed write byte |
| wr_addr | output | AW | Register index of the strobed write |
| wr_data | output | 8 | Data of the strobed write |

## Verification
The hardest cases to reach from the ports are the frozen time copy and the two wraps. The bench starts a read at register 0 and runs it for seventeen bytes. It changes `live_time` after the first byte, so the seventeenth byte reads register 0 again and must return the old value. A second transaction must then return the new one. Aborts are reached by dropping chip enable five bits into a write byte and three bits into a read byte. The write target is then read back, and the output enable is watched on every clock after the abort.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WR,
    PH_RD
  } phase_t;
endpackage

// File: rtl/ser3w_sync.sv
// Multi-flop synchronizer, one chain per input bit.
module ser3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ser3w_edge.sv
// Edge detector on already synchronized signals; edges align with q.
module ser3w_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= q;
  end

  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/ser3w_regs.sv
// Register file; the low TIME_N entries also take a parallel snapshot.
module ser3w_regs #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int TIME_N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snap,
  input  logic [TIME_N*DW-1:0] live,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [AW-1:0]        raddr,
  output logic [DW-1:0]        rdata
);
  localparam int NREG = 1 << AW;

  logic [NREG*DW-1:0] flat;

  for (genvar e = 0; e < NREG; e++) begin : g_ent
    logic [DW-1:0] ent;
    if (e < TIME_N) begin : g_time
      always_ff @(posedge clk) begin
        if (rst)                          ent <= '0;
        else if (snap)                    ent <= live[e*DW +: DW];
        else if (we && waddr == AW'(e))   ent <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                          ent <= '0;
        else if (we && waddr == AW'(e))   ent <= wdata;
      end
    end
    assign flat[e*DW +: DW] = ent;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= flat[raddr*DW +: DW];
  end
endmodule

// File: rtl/ser3w_slave.sv
module ser3w_slave
  import ser3w_pkg::*;
#(
  parameter int AW          = 4,
  parameter int TIME_N      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce_in,
  input  logic                     sclk_in,
  input  logic                     sio_in,
  output logic                     sio_out,
  output logic                     sio_oe,
  input  logic [TIME_N*BYTE_W-1:0] live_time,
  output logic                     wr_stb,
  output logic [AW-1:0]            wr_addr,
  output logic [BYTE_W-1:0]        wr_data
);
  localparam int CW = $clog2(BYTE_W);

  // Bit 0 chip enable, bit 1 serial clock, bit 2 data.
  logic [2:0] sq;
  logic [1:0] erise, efall;

  ser3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sio_in, sclk_in, ce_in}),
    .q   (sq)
  );

  ser3w_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .q    (sq[1:0]),
    .rise (erise),
    .fall (efall)
  );

  logic s_ce, s_din, ce_rise, ce_fall, sck_rise, sck_fall;
  assign s_ce     = sq[0];
  assign s_din    = sq[2];
  assign ce_rise  = erise[0];
  assign ce_fall  = efall[0];
  assign sck_rise = erise[1];
  assign sck_fall = efall[1];

  phase_t              phase;
  logic [CW-1:0]       bcnt, fcnt;
  logic [BYTE_W-2:0]   sh, osh;
  logic [AW-1:0]       addr;
  logic [BYTE_W-1:0]   rd_q, nxt_byte, out_word;

  assign nxt_byte = {s_din, sh};
  assign out_word = (fcnt == '0) ? rd_q : {1'b0, osh};

  ser3w_regs #(.AW(AW), .DW(BYTE_W), .TIME_N(TIME_N)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .snap  (ce_rise),
    .live  (live_time),
    .we    (wr_stb),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (addr),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bcnt    <= '0;
      fcnt    <= '0;
      sh      <= '0;
      osh     <= '0;
      addr    <= '0;
      sio_out <= 1'b0;
      sio_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (ce_fall) begin
        phase  <= PH_IDLE;
        sio_oe <= 1'b0;
        bcnt   <= '0;
        fcnt   <= '0;
      end else if (ce_rise) begin
        phase  <= PH_ADDR;
        sio_oe <= 1'b0;
        bcnt   <= '0;
        fcnt   <= '0;
      end else if (phase != PH_IDLE) begin
        if (sck_rise) begin
          sh   <= nxt_byte[BYTE_W-1:1];
          bcnt <= bcnt + 1'b1;
          if (bcnt == CW'(BYTE_W - 1)) begin
            case (phase)
              PH_ADDR: begin
                addr  <= nxt_byte[AW-1:0];
                phase <= nxt_byte[BYTE_W-1] ? PH_WR : PH_RD;
              end
              PH_WR: begin
                wr_stb  <= 1'b1;
                wr_addr <= addr;
                wr_data <= nxt_byte;
                addr    <= addr + 1'b1;
              end
              PH_RD:   addr <= addr + 1'b1;
              default: ;
            endcase
          end
        end else if (sck_fall && phase == PH_RD) begin
          sio_out <= out_word[0];
          osh     <= out_word[BYTE_W-1:1];
          fcnt    <= fcnt + 1'b1;
          sio_oe  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ser3w_chk.sv
module ser3w_chk (
  input logic clk,
  input logic rst,
  input logic s_ce,
  input logic sck_fall,
  input logic wr_stb,
  input logic oe
);
  // R10
  a_r10_stb_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R8
  a_r8_oe_drops_without_ce: assert property (@(posedge clk) disable iff (rst)
    !s_ce |=> !oe);

  // R8
  a_r8_oe_starts_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(sck_fall));

  // R7
  a_r7_no_stb_without_ce: assert property (@(posedge clk) disable iff (rst)
    !s_ce |=> !wr_stb);

  // R3
  a_r3_write_never_drives: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !oe);

  // R9
  always @(posedge clk) begin
    if (rst) a_r9_reset_quiet: assert (!wr_stb || !oe);
  end
endmodule

bind ser3w_slave ser3w_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_ce     (s_ce),
  .sck_fall (sck_fall),
  .wr_stb   (wr_stb),
  .oe       (sio_oe)
);

// File: tb/sim_ser3w_slave.sv
module sim_ser3w_slave;
  localparam int CLK_P  = 10;
  localparam int HALF   = 8 * CLK_P;
  localparam int AW     = 4;
  localparam int TIME_N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sio_out, sio_oe, wr_stb;
  logic [TIME_N*8-1:0] live_time = 64'h8877665544332211;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  ser3w_slave #(.AW(AW), .TIME_N(TIME_N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .ce_in(ce), .sclk_in(sclk), .sio_in(sdi),
    .sio_out(sio_out), .sio_oe(sio_oe), .live_time(live_time),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_P / 2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0]  model [16];
  logic [11:0] exp_q[$];
  bit   quiet = 1;
  int   low_cnt = 0;
  bit   prev_stb = 0;
  int   chg_at = -1;
  logic [TIME_N*8-1:0] live_next = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (ce) low_cnt <= 0;
    else if (low_cnt < 1000) low_cnt <= low_cnt + 1;
  end

  // Per-clock comparison against the reference model.
  always @(negedge clk) begin
    if (!rst) begin
      if (quiet || (!ce && low_cnt >= 4))
        check(!sio_oe, "R8", "oe while not in read data", sio_oe, 0);
      if (wr_stb) begin
        check(!prev_stb, "R10", "strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0)
          check(0, "R7", "unexpected write strobe", {wr_addr, wr_data}, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R3", "strobe addr/data", {wr_addr, wr_data}, e);
        end
      end
      prev_stb <= wr_stb;
    end
  end

  task automatic bus_bit(input logic b, output logic got, output logic oe_s);
    sclk = 1'b0;
    sdi  = b;
    #(HALF);
    got  = sio_out;
    oe_s = sio_oe;
    sclk = 1'b1;
    #(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic g, o;
    for (int i = 0; i < 8; i++) bus_bit(v[i], g, o);
  endtask

  task automatic recv_byte(output logic [7:0] v, output bit oe_all);
    logic g, o;
    oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b0, g, o);
      v[i] = g;
      if (o !== 1'b1) oe_all = 0;
    end
  endtask

  task automatic start();
    for (int i = 0; i < TIME_N; i++) model[i] = live_time[i*8 +: 8];
    quiet = 1;
    ce = 1'b1;
    #(HALF);
  endtask

  task automatic stop();
    ce = 1'b0;
    quiet = 0;
    #(HALF);
    sclk = 1'b0;
    #(2 * HALF);
  endtask

  task automatic wr_burst(input logic [7:0] abyte, input logic [7:0] d[$], input string req);
    logic [3:0] a;
    a = abyte[3:0];
    start();
    send_byte(abyte);
    foreach (d[k]) begin
      model[a] = d[k];
      exp_q.push_back({a, d[k]});
      send_byte(d[k]);
      a = a + 4'd1;
    end
    stop();
    check(exp_q.size() == 0, req, "missing write strobes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic rd_burst(input logic [7:0] abyte, input int n, input string req);
    logic [3:0] a;
    logic [7:0] v;
    bit oe_all;
    a = abyte[3:0];
    start();
    send_byte(abyte);
    quiet = 0;
    for (int k = 0; k < n; k++) begin
      if (k == chg_at) live_time = live_next;
      recv_byte(v, oe_all);
      check(v == model[a], req, $sformatf("read byte %0d at reg %0h", k, a), v, model[a]);
      check(oe_all, "R8", "oe during read bits", oe_all, 1);
      a = a + 4'd1;
    end
    stop();
  endtask

  initial begin
    logic g, o;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!sio_oe, "R9", "oe in reset", sio_oe, 0);
    check(!wr_stb, "R9", "strobe in reset", wr_stb, 0);
    @(posedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!sio_oe && !wr_stb, "R9", "outputs after reset", {sio_oe, wr_stb}, 0);

    // R9: untouched plain register reads zero
    rd_burst(8'h0C, 1, "R9");
    // R1, R2, R3: single write, asymmetric pattern
    wr_burst(8'h85, '{8'hA5}, "R3");
    wr_burst(8'h89, '{8'h1E}, "R1");
    rd_burst(8'h05, 1, "R1");
    rd_burst(8'h09, 1, "R1");
    // R4: write burst wraps 0x8F -> 0x80
    wr_burst(8'h8E, '{8'h3C, 8'hC3, 8'h5A, 8'h0F}, "R4");
    // R5: read burst wraps 0x0F -> 0x00 (0,1 are time copies)
    rd_burst(8'h0E, 4, "R5");
    // R2: bits 6:4 ignored in both directions
    wr_burst(8'hFA, '{8'h6B}, "R2");
    rd_burst(8'h4A, 1, "R2");
    // R6: live value changes mid burst; wrapped reread stays frozen
    live_next = 64'hF0E1D2C3B4A59687;
    chg_at = 1;
    rd_burst(8'h00, 17, "R6");
    chg_at = -1;
    rd_burst(8'h00, 2, "R6");
    // R7: abort five bits into a write byte
    start();
    send_byte(8'h8B);
    for (int i = 0; i < 5; i++) bus_bit(1'b1, g, o);
    stop();
    check(exp_q.size() == 0, "R7", "queue after abort", exp_q.size(), 0);
    rd_burst(8'h0B, 1, "R7");
    // R8: abort three bits into a read byte, oe must fall
    start();
    send_byte(8'h05);
    quiet = 0;
    for (int i = 0; i < 3; i++) bus_bit(1'b0, g, o);
    check(o === 1'b1, "R8", "oe mid read before abort", o, 1);
    stop();
    check(!sio_oe, "R8", "oe after read abort", sio_oe, 0);
    rd_burst(8'h05, 1, "R8");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule